// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of a relative branch for a small 8-bit accumulator processor. A start pulse hands it a branch opcode, a signed 8-bit displacement, the address of the opcode, the six condition code flags and the level of the external interrupt request pin. It works out whether the branch is taken. It forms the next program counter, then raises a one-cycle done strobe a fixed number of cycles later. The unit never writes any flag.

The unit covers several groups of branches. One group tests flags directly: carry, zero, negative, half-carry and the interrupt mask. Other groups cover unsigned compares, signed compares and a test of the interrupt pin. The pin passes through a synchronizer, and its value is frozen when the instruction is accepted. An opcode outside the branch set produces an invalid strobe and no done strobe. While an instruction is in flight, further start pulses are ignored.

Top module: `brc_unit`

## Requirements
- R1: When the branch is taken, next_pc equals pc + 2 + the sign-extended displacement, modulo 2^16, so disp 0x80 reaches pc + 2 - 128 and disp 0x7F reaches pc + 2 + 127.
- R2: When the branch is not taken, next_pc equals pc + 2 modulo 2^16.
- R3: Opcode 0x20 is always taken. Opcode 0x21 is never taken, and it still completes with done and next_pc = pc + 2.
- R4: The flag input ccr is ordered {V,H,I,N,Z,C}, with V at bit 5 and C at bit 0. Opcode 0x22 is taken when (C|Z)=0 and 0x23 when (C|Z)=1. Opcode 0x24 is taken when C=0 and 0x25 when C=1.
- R5: Opcode 0x26 is taken when Z=0 and 0x27 when Z=1. Opcode 0x2A is taken when N=0 and 0x2B when N=1.
- R6: Opcode 0x28 is taken when H=0 and 0x29 when H=1. Opcode 0x2C is taken when I=0 and 0x2D when I=1.
- R7: Opcode 0x2E is taken when the interrupt pin reads low and 0x2F when it reads high. The pin passes through two flops, and the synchronized value present at the accepting edge is used. Pin changes in the start cycle or later do not affect that instruction.
- R8: The signed branches behave as follows: 0x90 is taken when N^V=0, 0x91 when N^V=1, 0x92 when Z|(N^V)=0, and 0x93 when Z|(N^V)=1.
- R9: Every instruction, taken or not, takes the same time. If start is sampled at edge E0, done, taken and next_pc are updated at edge E2. Done is high for exactly one cycle, and taken and next_pc then hold until the next completion.
- R10: Start is ignored from the accepting edge until the edge after done, including while done is high. An ignored start produces no done, no invalid strobe and no change to next_pc.
- R11: A start with an opcode outside 0x20..0x2F and 0x90..0x93 raises invalid for one cycle after the sampling edge. It produces no done strobe and leaves the unit able to accept a start at the next edge.
- R12: While rst_n is low, done, invalid and taken are 0 and next_pc is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a branch when the unit is idle |
| opcode | input | 8 | Branch opcode byte |
| disp | input | 8 | Signed displacement byte |
| pc | input | 16 | Address of the opcode byte |
| ccr | input | 6 | Flags {V,H,I,N,Z,C} |
| irq_pin | input | 1 | Asynchronous interrupt request pin level |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch outcome of the last completed instruction |
| next_pc | output | 16 | Next program counter of the last completed instruction |
| invalid | output | 1 | One-cycle strobe for a non-branch opcode |

## Verification
Two events can land in the same cycle: the completion of one instruction and the request for the next. The bench provokes this by holding start high, with a different opcode and PC, during the cycle in which done is raised. It judges the result by the absence of any further done or invalid strobe and by next_pc staying at the first result. A second collision occurs when the interrupt pin toggles in the very cycle start is asserted. The bench expects the pin value from before the toggle to decide 0x2E and 0x2F.

// File: rtl/brc_pkg.sv
package brc_pkg;

   typedef struct packed {
      logic v;
      logic h;
      logic i;
      logic n;
      logic z;
      logic c;
   } ccr_t;

   localparam logic [7:0] OP_REL_BASE  = 8'h20;
   localparam logic [7:0] OP_NEVER     = 8'h21;
   localparam logic [7:0] OP_SGN_BASE  = 8'h90;

   // Opcode membership in the branch set handled by the unit.
   function automatic logic op_known(input logic [7:0] op, input logic allow_never);
      logic in_rel, in_sgn;
      in_rel = (op[7:4] == OP_REL_BASE[7:4]);
      in_sgn = (op[7:2] == OP_SGN_BASE[7:2]);
      if (op == OP_NEVER && !allow_never)
         return 1'b0;
      return in_rel | in_sgn;
   endfunction

endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("brc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/brc_cond.sv
module brc_cond
   import brc_pkg::*;
#(
   parameter int OP_W        = 8,
   parameter bit ALLOW_NEVER = 1'b1
) (
   input  logic [OP_W-1:0] op,
   input  ccr_t            f,
   input  logic            pin,
   output logic            take
);
   generate
      if (OP_W != 8) begin : g_bad
         $error("brc_cond decodes 8-bit opcodes only");
      end
   endgenerate

   // Each opcode pair shares a base test; bit 0 inverts it.
   logic base_rel, base_sgn, nv;

   assign nv = f.n ^ f.v;

   generate
      if (ALLOW_NEVER) begin : g_never
         always_comb begin
            unique case (op[3:1])
               3'd0:    base_rel = 1'b1;
               3'd1:    base_rel = ~(f.c | f.z);
               3'd2:    base_rel = ~f.c;
               3'd3:    base_rel = ~f.z;
               3'd4:    base_rel = ~f.h;
               3'd5:    base_rel = ~f.n;
               3'd6:    base_rel = ~f.i;
               default: base_rel = ~pin;
            endcase
         end
      end else begin : g_no_never
         // 0x21 is rejected upstream; pair 0 reduces to the always case.
         always_comb begin
            unique case (op[3:1])
               3'd0:    base_rel = ~op[0];
               3'd1:    base_rel = ~(f.c | f.z);
               3'd2:    base_rel = ~f.c;
               3'd3:    base_rel = ~f.z;
               3'd4:    base_rel = ~f.h;
               3'd5:    base_rel = ~f.n;
               3'd6:    base_rel = ~f.i;
               default: base_rel = ~pin;
            endcase
         end
      end
   endgenerate

   assign base_sgn = op[1] ? ~(f.z | nv) : ~nv;

   always_comb begin
      if (op[7])
         take = base_sgn ^ op[0];
      else if (ALLOW_NEVER || op[3:1] != 3'd0)
         take = base_rel ^ op[0];
      else
         take = base_rel;
   end

   // R3: the unconditional opcode must always resolve taken.
   always_comb begin
      if (op == OP_REL_BASE)
         a_always_r3 : assert (take);
   end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
   parameter int PC_W      = 16,
   parameter int DISP_W    = 8,
   parameter int INSTR_LEN = 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              take,
   output logic [PC_W-1:0]   next
);
   localparam int EXT_W = PC_W - DISP_W;

   generate
      if (PC_W <= DISP_W) begin : g_bad
         $error("brc_target: PC must be wider than the displacement");
      end
   endgenerate

   logic [PC_W-1:0] fall, offs;

   assign fall = pc + PC_W'(INSTR_LEN);
   assign offs = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign next = take ? fall + offs : fall;
endmodule

// File: rtl/brc_unit.sv
module brc_unit
   import brc_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int DISP_W      = 8,
   parameter int LATENCY     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int INSTR_LEN   = 2,
   parameter bit ALLOW_NEVER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DISP_W-1:0] disp,
   input  logic [PC_W-1:0]   pc,
   input  logic [5:0]        ccr,
   input  logic              irq_pin,
   output logic              done,
   output logic              taken,
   output logic [PC_W-1:0]   next_pc,
   output logic              invalid
);
   localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

   generate
      if (LATENCY < 2) begin : g_bad_lat
         $error("brc_unit: LATENCY must be at least 2");
      end
   endgenerate

   logic              pin_s;
   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        op_q;
   logic [DISP_W-1:0] disp_q;
   logic [PC_W-1:0]   pc_q;
   ccr_t              ccr_q;
   logic              pin_q;
   logic              take_c;
   logic [PC_W-1:0]   next_c;
   logic              done_q, invalid_q, taken_q;
   logic [PC_W-1:0]   npc_q;

   brc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s)
   );

   brc_cond #(.OP_W(8), .ALLOW_NEVER(ALLOW_NEVER)) u_cond (
      .op(op_q), .f(ccr_q), .pin(pin_q), .take(take_c)
   );

   brc_target #(.PC_W(PC_W), .DISP_W(DISP_W), .INSTR_LEN(INSTR_LEN)) u_tgt (
      .pc(pc_q), .disp(disp_q), .take(take_c), .next(next_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         op_q      <= '0;
         disp_q    <= '0;
         pc_q      <= '0;
         ccr_q     <= '0;
         pin_q     <= 1'b0;
         done_q    <= 1'b0;
         invalid_q <= 1'b0;
         taken_q   <= 1'b0;
         npc_q     <= '0;
      end else begin
         done_q    <= 1'b0;
         invalid_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               if (op_known(opcode, ALLOW_NEVER)) begin
                  op_q   <= opcode;
                  disp_q <= disp;
                  pc_q   <= pc;
                  ccr_q  <= ccr_t'(ccr);
                  pin_q  <= pin_s;
                  busy_q <= 1'b1;
                  cnt_q  <= '0;
               end else begin
                  invalid_q <= 1'b1;
               end
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST - 1'b1) begin
               done_q  <= 1'b1;
               taken_q <= take_c;
               npc_q   <= next_c;
            end
            if (cnt_q == LAST)
               busy_q <= 1'b0;
         end
      end
   end

   assign done    = done_q;
   assign invalid = invalid_q;
   assign taken   = taken_q;
   assign next_pc = npc_q;

   // R9: completion strobe lasts exactly one cycle
   p_done_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: completion only ever follows an accepted instruction
   p_done_busy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_q);

   // R10: a start while busy leaves the latched instruction untouched
   p_start_ignored_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> ($stable(op_q) && $stable(pc_q) && $stable(disp_q)));

   // R11: an invalid strobe never coincides with completion or activity
   p_invalid_no_done_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> (!done && !busy_q));

   // R2: a not-taken outcome lands right after the instruction
   p_fall_through_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !taken) |-> (next_pc == pc_q + PC_W'(INSTR_LEN)));

   // R3: branch-never completes untaken
   p_never_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_NEVER) |-> !taken);
endmodule

// File: tb/sim_brc_unit.sv
module sim_brc_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  disp = 8'h00;
   logic [15:0] pc = 16'h0000;
   logic [5:0]  ccr = 6'h00;
   logic        irq_pin = 1'b0;
   logic        done, taken, invalid;
   logic [15:0] next_pc;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brc_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
      .pc(pc), .ccr(ccr), .irq_pin(irq_pin), .done(done), .taken(taken),
      .next_pc(next_pc), .invalid(invalid)
   );

   // Reference outcome, written per opcode from the requirements.
   function automatic logic ref_take(input logic [7:0] op, input logic [5:0] f, input logic p);
      logic v, h, i, n, z, c;
      {v, h, i, n, z, c} = f;
      case (op)
         8'h20: return 1'b1;
         8'h21: return 1'b0;
         8'h22: return (c | z) == 1'b0;
         8'h23: return (c | z) == 1'b1;
         8'h24: return c == 1'b0;
         8'h25: return c == 1'b1;
         8'h26: return z == 1'b0;
         8'h27: return z == 1'b1;
         8'h28: return h == 1'b0;
         8'h29: return h == 1'b1;
         8'h2A: return n == 1'b0;
         8'h2B: return n == 1'b1;
         8'h2C: return i == 1'b0;
         8'h2D: return i == 1'b1;
         8'h2E: return p == 1'b0;
         8'h2F: return p == 1'b1;
         8'h90: return (n ^ v) == 1'b0;
         8'h91: return (n ^ v) == 1'b1;
         8'h92: return (z | (n ^ v)) == 1'b0;
         8'h93: return (z | (n ^ v)) == 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] ref_pc(input logic [15:0] a, input logic [7:0] d, input logic t);
      logic [15:0] s;
      s = {{8{d[7]}}, d};
      return t ? a + 16'd2 + s : a + 16'd2;
   endfunction

   function automatic string req_of(input logic [7:0] op);
      case (op)
         8'h20, 8'h21: return "R3";
         8'h22, 8'h23, 8'h24, 8'h25: return "R4";
         8'h26, 8'h27, 8'h2A, 8'h2B: return "R5";
         8'h28, 8'h29, 8'h2C, 8'h2D: return "R6";
         8'h2E, 8'h2F: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Runs one instruction; the pin must already be settled by the caller.
   task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic [15:0] a,
                         input logic [5:0] f, input logic exp_pin, input string req);
      logic t;
      logic [15:0] np;
      t  = ref_take(op, f, exp_pin);
      np = ref_pc(a, d, t);
      @(negedge clk);
      opcode = op; disp = d; pc = a; ccr = f; start = 1'b1;
      @(negedge clk);                        // after E0
      start = 1'b0;
      chk(!invalid && !done, "R9", "no strobe after accept", {invalid, done}, 0);
      @(negedge clk);                        // after E1
      chk(!done, "R9", "done early", done, 0);
      @(negedge clk);                        // after E2
      chk(done, "R9", "done at third cycle", done, 1);
      chk(taken == t, req, $sformatf("taken op=%02h", op), taken, t);
      chk(next_pc == np, t ? "R1" : "R2", $sformatf("next_pc op=%02h", op), next_pc, np);
   endtask

   task automatic settle_pin(input logic p);
      @(negedge clk);
      irq_pin = p;
      repeat (3) @(negedge clk);
   endtask

   logic [7:0] valid_ops [20] = '{8'h20,8'h21,8'h22,8'h23,8'h24,8'h25,8'h26,8'h27,
                                  8'h28,8'h29,8'h2A,8'h2B,8'h2C,8'h2D,8'h2E,8'h2F,
                                  8'h90,8'h91,8'h92,8'h93};

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(!done && !invalid && !taken && next_pc == 16'h0, "R12", "reset outputs",
          {done, invalid, taken, next_pc}, 0);
      rst_n = 1'b1;
      settle_pin(1'b0);

      // Directed corners
      run_op(8'h20, 8'h7F, 16'h1000, 6'h00, 1'b0, "R3");     // R1 max forward
      run_op(8'h20, 8'h80, 16'h1000, 6'h00, 1'b0, "R3");     // R1 max backward
      run_op(8'h20, 8'h10, 16'hFFF8, 6'h00, 1'b0, "R3");     // R1 wrap up
      run_op(8'h20, 8'hF0, 16'h0004, 6'h00, 1'b0, "R3");     // R1 wrap down
      run_op(8'h21, 8'h40, 16'hFFFF, 6'h3F, 1'b0, "R3");     // R2 wrap, never
      run_op(8'h22, 8'h05, 16'h0200, 6'h00, 1'b0, "R4");
      run_op(8'h23, 8'h05, 16'h0200, 6'h02, 1'b0, "R4");
      run_op(8'h29, 8'h05, 16'h0300, 6'h10, 1'b0, "R6");
      run_op(8'h2C, 8'h05, 16'h0300, 6'h08, 1'b0, "R6");
      run_op(8'h91, 8'h05, 16'h0400, 6'h20, 1'b0, "R8");     // V only
      run_op(8'h92, 8'h05, 16'h0400, 6'h24, 1'b0, "R8");     // N=V=1

      // R7: pin high settled, toggled low in the start cycle -> old value used
      settle_pin(1'b1);
      @(negedge clk);
      irq_pin = 1'b0;
      opcode = 8'h2F; disp = 8'h20; pc = 16'h0500; start = 1'b1;
      @(negedge clk); start = 1'b0; irq_pin = 1'b1;
      @(negedge clk); irq_pin = 1'b0;
      @(negedge clk);
      chk(done && taken, "R7", "pin frozen at accept", {done, taken}, 2'b11);
      settle_pin(1'b0);
      run_op(8'h2E, 8'h02, 16'h0600, 6'h00, 1'b0, "R7");

      // R10: start during the done cycle is ignored
      run_op(8'h20, 8'h08, 16'h0700, 6'h00, 1'b0, "R3");
      opcode = 8'h21; pc = 16'h9000; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk(!done && !invalid, "R10", "start during done ignored", {done, invalid}, 0);
         chk(next_pc == 16'h070A, "R10", "next_pc held", next_pc, 16'h070A);
         @(negedge clk);
      end
      // R10: start mid-flight with an invalid opcode is ignored too
      @(negedge clk);
      opcode = 8'h24; disp = 8'h00; pc = 16'h0800; ccr = 6'h00; start = 1'b1;
      @(negedge clk); opcode = 8'h55; // unit busy now
      @(negedge clk); start = 1'b0;
      chk(!invalid, "R10", "busy start no invalid", invalid, 0);
      @(negedge clk);
      chk(done && next_pc == 16'h0802, "R10", "first op completes", next_pc, 16'h0802);

      // R11: invalid opcode
      @(negedge clk);
      opcode = 8'h94; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(invalid, "R11", "invalid strobe", invalid, 1);
      @(negedge clk);
      chk(!invalid, "R11", "invalid one cycle", invalid, 0);
      for (int k = 0; k < 3; k++) begin
         chk(!done, "R11", "no done after invalid", done, 0);
         @(negedge clk);
      end
      // R11: back-to-back invalid then valid accepted at next edge
      opcode = 8'h1F; start = 1'b1;
      @(negedge clk);
      opcode = 8'h27; disp = 8'hFE; pc = 16'h0A00; ccr = 6'h02;
      chk(invalid, "R11", "invalid 0x1F", invalid, 1);
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(done && taken && next_pc == 16'h0A00, "R11", "valid after invalid", next_pc, 16'h0A00);

      // Random sweep
      for (int it = 0; it < 300; it++) begin
         logic [7:0] op;
         logic p;
         op = valid_ops[$urandom_range(0, 19)];
         p  = 1'($urandom_range(0, 1));
         if (p != irq_pin) settle_pin(p);
         run_op(op, 8'($urandom), 16'($urandom), 6'($urandom), p, req_of(op));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule